// File: doc/BRIEF.md
# Ternary Reed-Muller Truth-Vector Transform Engine

This block converts the 27 coefficients of a three-variable ternary Reed-Muller polynomial into the 27 values of the function it describes. Coefficients are written one at a time into an internal buffer. A start pulse then launches the transform. The transform runs as three in-place passes over the buffer. Each pass applies the one-variable modulo-3 matrix along one base-3 digit of the index, so the full 27×27 matrix is never formed.

When the third pass ends, the block raises a one-cycle done flag. In that same cycle it begins streaming the truth vector in index order, one entry per cycle. The results stay in the buffer, so a second start without a new load transforms them again. While a transform or a stream is in progress, the block ignores both loads and start pulses.

Top module: `ternary_rm_xform`

## Requirements
- R1: While reset is asserted and after its release, done_o, out_valid_o and out_last_o are 0.
- R2: While idle, a load with index 0..26 writes the coefficient at that index. The value codes are 00 = 0, 01 = 1 and 10 = 2, and the code 11 is stored as 0. A load with index 27..31 changes nothing.
- R3: Each streamed entry j = 9·x1 + 3·x2 + x3 (x1 is the most significant digit) equals the sum, modulo 3, of a(i)·x1^i1·x2^i2·x3^i3 over all coefficient indices i = 9·i1 + 3·i2 + i3, where 0^0 = 1. Output values use the same 2-bit codes as R2.
- R4: If only coefficients 0..8 are nonzero and equal [1 1 0 0 2 0 0 0 0], the output is [1 2 0 1 1 1 1 0 2] repeated three times.
- R5: done_o is high for exactly one cycle: the 27th cycle after the clock edge that samples start. It is low in all other cycles of the run.
- R6: Entry 0 appears in the same cycle as done_o. Entries 0..26 then follow on consecutive cycles with out_valid_o high, out_last_o is high only on entry 26, and out_valid_o falls in the next cycle.
- R7: A start pulse or a load that arrives during the passes or the stream has no effect on the results, on the timing, or on the buffer.
- R8: After a stream, the buffer holds the truth vector. A new start without a load streams the transform of that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start a transform (sampled only while idle) |
| ld_en_i | input | 1 | Coefficient write strobe (sampled only while idle) |
| ld_idx_i | input | 5 | Coefficient index |
| ld_val_i | input | 2 | Coefficient value |
| done_o | output | 1 | One-cycle pulse when the transform completes |
| out_valid_o | output | 1 | Streamed entry valid |
| out_data_o | output | 2 | Streamed truth-vector entry |
| out_last_o | output | 1 | Marks entry 26 |

## Verification
Take S as the clock edge that samples start. The 27 pass cycles finish at edge S+27, so done_o and entry 0 are visible after that edge. Entry j is visible after edge S+27+j, and the block is idle again after edge S+54. The bench raises start on a falling edge and lowers it on the next one. From then on it counts falling edges and checks every output at the falling edge that follows each of these rising edges. It checks done_o and out_valid_o low for the 26 pass cycles between. Expected vectors come from evaluating the polynomial point by point, which is a different method from the factored passes.

// File: rtl/trm_pkg.sv
package trm_pkg;

  typedef logic [1:0] trit_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PASS   = 2'd1,
    ST_STREAM = 2'd2
  } state_t;

  function automatic int pow3(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction

  // modulo-3 sum of two canonical trits
  function automatic trit_t t_add(input trit_t a, input trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // modulo-3 doubling
  function automatic trit_t t_dbl(input trit_t a);
    trit_t r;
    case (a)
      2'd1:    r = 2'd2;
      2'd2:    r = 2'd1;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

  function automatic trit_t t_fold(input trit_t a);
    return (a == 2'b11) ? 2'b00 : a;
  endfunction

endpackage

// File: rtl/trm_seq.sv
module trm_seq #(
  parameter int DIGITS = 3,
  parameter int N      = 27,
  parameter int TRIPS  = 9,
  parameter int IW     = 5,
  parameter int TW     = 4,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          idle_o,
  output logic          wr_en_o,
  output logic [PW-1:0] pass_o,
  output logic [TW-1:0] trip_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          done_o,
  output logic          out_valid_o,
  output logic          out_last_o
);
  import trm_pkg::*;

  state_t        state_q, state_d;
  logic [PW-1:0] pass_q, pass_d;
  logic [TW-1:0] trip_q, trip_d;
  logic [IW-1:0] rd_q, rd_d;
  logic          done_q, done_d;
  logic          ctr_en;

  logic trip_wrap, pass_wrap, rd_wrap;
  assign trip_wrap = (trip_q == TW'(TRIPS - 1));
  assign pass_wrap = (pass_q == PW'(DIGITS - 1));
  assign rd_wrap   = (rd_q == IW'(N - 1));

  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    trip_d  = trip_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PASS;
          pass_d  = '0;
          trip_d  = '0;
        end
      end
      ST_PASS: begin
        if (trip_wrap) begin
          trip_d = '0;
          if (pass_wrap) begin
            state_d = ST_STREAM;
            rd_d    = '0;
            done_d  = 1'b1;
          end else begin
            pass_d = pass_q + 1'b1;
          end
        end else begin
          trip_d = trip_q + 1'b1;
        end
      end
      ST_STREAM: begin
        if (rd_wrap) state_d = ST_IDLE;
        else         rd_d    = rd_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctr_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      trip_q  <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (ctr_en) begin
        state_q <= state_d;
        pass_q  <= pass_d;
        trip_q  <= trip_d;
        rd_q    <= rd_d;
      end
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign wr_en_o     = (state_q == ST_PASS);
  assign pass_o      = pass_q;
  assign trip_o      = trip_q;
  assign rd_idx_o    = rd_q;
  assign done_o      = done_q;
  assign out_valid_o = (state_q == ST_STREAM);
  assign out_last_o  = (state_q == ST_STREAM) && rd_wrap;

  // R5: completion flag never lasts two cycles
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: stream ends right after the last marker
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |=> !out_valid_o);

  // R6: first streamed entry coincides with the done pulse
  assert_first_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> done_o);

  // R7: a start during the passes never returns the engine to idle
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASS && start_i) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/trm_addr.sv
module trm_addr #(
  parameter int DIGITS = 3,
  parameter int N      = 27,
  parameter int IW     = 5,
  parameter int TW     = 4,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [PW-1:0] pass_i,
  input  logic [TW-1:0] trip_i,
  output logic [IW-1:0] idx0_o,
  output logic [IW-1:0] idx1_o,
  output logic [IW-1:0] idx2_o
);
  import trm_pkg::*;

  logic [IW-1:0] lane0 [DIGITS];
  logic [IW-1:0] lane1 [DIGITS];
  logic [IW-1:0] lane2 [DIGITS];

  // pass p walks the digit of weight 3^p (least significant digit first)
  for (genvar p = 0; p < DIGITS; p++) begin : g_pass
    localparam int STRIDE = pow3(p);
    logic [IW-1:0] base;
    assign base     = IW'((int'(trip_i) / STRIDE) * (3 * STRIDE) + (int'(trip_i) % STRIDE));
    assign lane0[p] = base;
    assign lane1[p] = base + IW'(STRIDE);
    assign lane2[p] = base + IW'(2 * STRIDE);
  end

  always_comb begin
    idx0_o = '0;
    idx1_o = '0;
    idx2_o = '0;
    for (int p = 0; p < DIGITS; p++) begin
      if (pass_i == PW'(p)) begin
        idx0_o = lane0[p];
        idx1_o = lane1[p];
        idx2_o = lane2[p];
      end
    end
  end

  // R3: a triple addresses three distinct in-range entries, equally spaced
  assert_triple_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (idx0_o < IW'(N) && idx1_o < IW'(N) && idx2_o < IW'(N) &&
              idx0_o < idx1_o && idx1_o < idx2_o &&
              (idx1_o - idx0_o) == (idx2_o - idx1_o)));

endmodule

// File: rtl/trm_butterfly.sv
module trm_butterfly (
  input  trm_pkg::trit_t v0_i,
  input  trm_pkg::trit_t v1_i,
  input  trm_pkg::trit_t v2_i,
  output trm_pkg::trit_t y0_o,
  output trm_pkg::trit_t y1_o,
  output trm_pkg::trit_t y2_o
);
  import trm_pkg::*;

  trit_t s01, s01d;

  // rows of the one-variable matrix: x=0 -> [1 0 0], x=1 -> [1 1 1], x=2 -> [1 2 1]
  assign s01  = t_add(v0_i, v1_i);
  assign s01d = t_add(v0_i, t_dbl(v1_i));
  assign y0_o = v0_i;
  assign y1_o = t_add(s01, v2_i);
  assign y2_o = t_add(s01d, v2_i);

endmodule

// File: rtl/trm_store.sv
module trm_store #(
  parameter int N  = 27,
  parameter int IW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_we_i,
  input  logic [IW-1:0]  ld_idx_i,
  input  trm_pkg::trit_t ld_val_i,
  input  logic           wr_en_i,
  input  logic [IW-1:0]  a0_i,
  input  logic [IW-1:0]  a1_i,
  input  logic [IW-1:0]  a2_i,
  input  trm_pkg::trit_t y0_i,
  input  trm_pkg::trit_t y1_i,
  input  trm_pkg::trit_t y2_i,
  input  logic [IW-1:0]  rd_idx_i,
  output trm_pkg::trit_t v0_o,
  output trm_pkg::trit_t v1_o,
  output trm_pkg::trit_t v2_o,
  output trm_pkg::trit_t rd_o
);
  import trm_pkg::*;

  trit_t mem_q [N];
  trit_t mem_d [N];
  logic  mem_en;

  assign mem_en = ld_we_i || wr_en_i;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      mem_d[e] = mem_q[e];
      if (ld_we_i && ld_idx_i == IW'(e)) mem_d[e] = t_fold(ld_val_i);
      if (wr_en_i) begin
        if (a0_i == IW'(e)) mem_d[e] = y0_i;
        if (a1_i == IW'(e)) mem_d[e] = y1_i;
        if (a2_i == IW'(e)) mem_d[e] = y2_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) mem_q[e] <= '0;
    end else if (mem_en) begin
      for (int e = 0; e < N; e++) mem_q[e] <= mem_d[e];
    end
  end

  always_comb begin
    v0_o = '0;
    v1_o = '0;
    v2_o = '0;
    rd_o = '0;
    for (int e = 0; e < N; e++) begin
      if (a0_i == IW'(e))     v0_o = mem_q[e];
      if (a1_i == IW'(e))     v1_o = mem_q[e];
      if (a2_i == IW'(e))     v2_o = mem_q[e];
      if (rd_idx_i == IW'(e)) rd_o = mem_q[e];
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_chk
    // R2: the unused code never lands in the buffer
    assert_no_code3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_q[e] != 2'b11);
    // R7: without an accepted load or a pass write the entry holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_we_i && !wr_en_i) |=> $stable(mem_q[e]));
  end

endmodule

// File: rtl/ternary_rm_xform.sv
module ternary_rm_xform #(
  parameter int DIGITS = 3
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start_i,
  input  logic                                        ld_en_i,
  input  logic [$clog2(trm_pkg::pow3(DIGITS))-1:0]    ld_idx_i,
  input  logic [1:0]                                  ld_val_i,
  output logic                                        done_o,
  output logic                                        out_valid_o,
  output logic [1:0]                                  out_data_o,
  output logic                                        out_last_o
);
  import trm_pkg::*;

  localparam int N     = pow3(DIGITS);
  localparam int IW    = $clog2(N);
  localparam int TRIPS = N / 3;
  localparam int TW    = (TRIPS > 1) ? $clog2(TRIPS) : 1;
  localparam int PW    = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic          idle, wr_en;
  logic [PW-1:0] pass;
  logic [TW-1:0] trip;
  logic [IW-1:0] rd_idx, a0, a1, a2;
  trit_t         v0, v1, v2, y0, y1, y2, rd_val;
  logic          ld_we;

  assign ld_we = ld_en_i && idle;

  trm_seq #(
    .DIGITS(DIGITS), .N(N), .TRIPS(TRIPS), .IW(IW), .TW(TW), .PW(PW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .idle_o(idle), .wr_en_o(wr_en), .pass_o(pass), .trip_o(trip),
    .rd_idx_o(rd_idx), .done_o(done_o),
    .out_valid_o(out_valid_o), .out_last_o(out_last_o)
  );

  trm_addr #(
    .DIGITS(DIGITS), .N(N), .IW(IW), .TW(TW), .PW(PW)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .en_i(wr_en),
    .pass_i(pass), .trip_i(trip),
    .idx0_o(a0), .idx1_o(a1), .idx2_o(a2)
  );

  trm_butterfly u_bfly (
    .v0_i(v0), .v1_i(v1), .v2_i(v2),
    .y0_o(y0), .y1_o(y1), .y2_o(y2)
  );

  trm_store #(.N(N), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_we_i(ld_we), .ld_idx_i(ld_idx_i), .ld_val_i(ld_val_i),
    .wr_en_i(wr_en), .a0_i(a0), .a1_i(a1), .a2_i(a2),
    .y0_i(y0), .y1_i(y1), .y2_i(y2),
    .rd_idx_i(rd_idx),
    .v0_o(v0), .v1_o(v1), .v2_o(v2), .rd_o(rd_val)
  );

  assign out_data_o = out_valid_o ? rd_val : 2'b00;

  // R6: output code stays canonical while streaming
  assert_out_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_data_o != 2'b11));

endmodule

// File: tb/ternary_rm_xform_tb_top.sv
`timescale 1ns/1ps
module ternary_rm_xform_tb_top;

  typedef int vec_t [27];

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       ld_en_i;
  logic [4:0] ld_idx_i;
  logic [1:0] ld_val_i;
  logic       done_o, out_valid_o, out_last_o;
  logic [1:0] out_data_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  ternary_rm_xform dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_val_i(ld_val_i),
    .done_o(done_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int pw3(input int b, input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r % 3;
  endfunction

  // point-by-point polynomial evaluation
  function automatic vec_t ref_xf(input vec_t a);
    vec_t x;
    for (int xi = 0; xi < 27; xi++) begin
      int s = 0;
      for (int i = 0; i < 27; i++) begin
        int ai = (a[i] == 3) ? 0 : a[i];
        s += ai * pw3(xi / 9, i / 9) * pw3((xi / 3) % 3, (i / 3) % 3) * pw3(xi % 3, i % 3);
      end
      x[xi] = s % 3;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t a);
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      ld_en_i  = 1'b1;
      ld_idx_i = 5'(i);
      ld_val_i = 2'(a[i]);
    end
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic run(input vec_t exp, input string req, input bit poke);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);          // edge S sampled start
    start_i = 1'b0;
    for (int c = 1; c <= 26; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      ld_en_i = 1'b0;
      check(!done_o && !out_valid_o, "R5", "quiet during passes", int'(done_o), 0);
      if (poke && c == 5) begin   // R7: start and load during passes
        start_i  = 1'b1;
        ld_en_i  = 1'b1;
        ld_idx_i = 5'd13;
        ld_val_i = 2'd2;
      end
    end
    for (int j = 0; j < 27; j++) begin
      @(negedge clk);
      start_i = 1'b0;
      ld_en_i = 1'b0;
      check(out_valid_o == 1'b1, "R6", "valid", int'(out_valid_o), 1);
      check(int'(out_data_o) == exp[j], req, $sformatf("entry %0d", j), int'(out_data_o), exp[j]);
      check(out_last_o == (j == 26), "R6", $sformatf("last at %0d", j), int'(out_last_o), int'(j == 26));
      check(done_o == (j == 0), "R5", $sformatf("done at %0d", j), int'(done_o), int'(j == 0));
      if (poke && j == 3) begin   // R7: start and load during stream
        start_i  = 1'b1;
        ld_en_i  = 1'b1;
        ld_idx_i = 5'd0;
        ld_val_i = 2'd1;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    ld_en_i = 1'b0;
    check(!out_valid_o && !done_o, "R6", "idle after stream", int'(out_valid_o), 0);
    repeat (3) begin
      @(negedge clk);
      check(!out_valid_o && !done_o, "R7", "no restart from ignored start", int'(out_valid_o), 0);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    finished = 1;
    $finish;
  endtask

  initial begin
    #(4 * 30000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    vec_t a, e, e2;
    int unsigned seed;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    ld_en_i  = 1'b0;
    ld_idx_i = '0;
    ld_val_i = '0;
    repeat (3) @(negedge clk);
    check(!done_o, "R1", "done in reset", int'(done_o), 0);
    check(!out_valid_o, "R1", "valid in reset", int'(out_valid_o), 0);
    check(!out_last_o, "R1", "last in reset", int'(out_last_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done_o && !out_valid_o && !out_last_o, "R1", "outputs after release", int'(out_valid_o), 0);

    // R4: two-variable case repeated across the top digit
    foreach (a[i]) a[i] = 0;
    a[1] = 1; a[0] = 1; a[4] = 2;
    load_vec(a);
    e = '{1,2,0,1,1,1,1,0,2, 1,2,0,1,1,1,1,0,2, 1,2,0,1,1,1,1,0,2};
    run(e, "R4", 0);

    // R3: all-zero coefficients
    foreach (a[i]) a[i] = 0;
    load_vec(a);
    run(ref_xf(a), "R3", 0);

    // R3: every single-term polynomial, weights 1 and 2
    for (int k = 0; k < 27; k++) begin
      foreach (a[i]) a[i] = 0;
      a[k] = (k % 2 == 0) ? 1 : 2;
      load_vec(a);
      run(ref_xf(a), "R3", 0);
    end

    // R3: pseudo-random coefficient vectors
    seed = 32'h1357_2468;
    for (int r = 0; r < 5; r++) begin
      foreach (a[i]) begin
        seed = seed * 1103515245 + 12345;
        a[i] = int'((seed >> 16) % 3);
      end
      load_vec(a);
      run(ref_xf(a), "R3", 0);
    end

    // R2: code 11 stored as 0, loads beyond index 26 ignored
    foreach (a[i]) a[i] = (i * 7 + 1) % 3;
    a[4] = 3;
    a[20] = 3;
    load_vec(a);
    for (int i = 27; i < 32; i++) begin
      @(negedge clk);
      ld_en_i  = 1'b1;
      ld_idx_i = 5'(i);
      ld_val_i = 2'd2;
    end
    @(negedge clk);
    ld_en_i = 1'b0;
    run(ref_xf(a), "R2", 0);

    // R7: pokes during passes and stream are ignored; R8: buffer keeps result
    foreach (a[i]) a[i] = (i * 5 + 2) % 3;
    load_vec(a);
    e = ref_xf(a);
    run(e, "R7", 1);
    e2 = ref_xf(e);
    run(e2, "R8", 0);

    summary();
  end

endmodule